// File: doc/BRIEF.md
# Parallel Display Write Sequencer

This block writes a programmed number of bytes to a display over an 8-bit parallel bus with an active-low write strobe. A start pulse loads the transfer count. For each byte the sequencer runs the same fixed write cycle. It first puts the byte on the bus with the strobe high. It then pulls the strobe low for a parameterised number of cycles and releases it. Finally it waits for an end-of-cycle pulse from outside the clock domain. Only when that pulse is seen does it move on to the next byte.

Bytes come from an upstream source through a one-cycle fetch request and a valid strobe carrying the data. The request for the following byte goes out in the same cycle that the current byte is placed on the bus. This lets the refill overlap the strobe and the wait for the end pulse. If the byte has still not arrived when the next cycle is due, the sequencer keeps the strobe high and waits. The end-of-cycle pulse passes through a two-stage synchroniser and a rising-edge detector before it advances the completed-transfer counter. When the counter reaches the programmed total, the block raises a sticky done flag and stops.

Top module: `pdisp_wr_seq`

## Requirements
- R1: After reset the strobe `disp_wr_n_o` is 1, `done_o`, `busy_o` and `fetch_req_o` are 0, and `disp_data_o` is 0.
- R2: Every write cycle places the byte on the bus while the strobe is high. The strobe is then held at 0 for exactly STROBE_CYC cycles (default 2) and returns to 1. The data bus does not change while the strobe is 0.
- R3: For a programmed count N > 0, exactly N strobe pulses occur. The bytes seen at the falling strobe edges are the fetched bytes, in the order they were delivered.
- R4: `done_o` rises only after the synchronised end pulse of the N-th cycle. No strobe pulse occurs after that.
- R5: Each asynchronous end pulse, whatever its width (at least 2 clock cycles), advances the transfer count exactly once. An end pulse that arrives while no strobe cycle is waiting for it is ignored.
- R6: `fetch_req_o` is a one-cycle pulse. The first request goes out right after a start with N > 0. Each following request goes out in the cycle a byte is placed on the bus, but only while more bytes remain. Exactly N requests are made per run.
- R7: If the next byte has not been delivered when the next cycle is due, the strobe stays at 1 until it arrives. No byte is sent twice.
- R8: A start with count 0 sets `done_o` one cycle later. It produces no strobe pulse and no fetch request, and `busy_o` stays 0.
- R9: `done_o` stays set until the next accepted start, which clears it one cycle later and sets `busy_o`. A start while `busy_o` is 1 is ignored.
- R10: `fetch_vld_i` is ignored when no fetch request is outstanding.
- R11: After completion, `disp_data_o` keeps the last byte sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, loads the count when idle |
| xfer_cnt_i | input | CNT_W | Number of bytes to write |
| fetch_req_o | output | 1 | One-cycle request for the next byte |
| fetch_vld_i | input | 1 | Requested byte is present on fetch_data_i |
| fetch_data_i | input | DW | Byte from the upstream source |
| step_async_i | input | 1 | Asynchronous end-of-cycle pulse |
| disp_data_o | output | DW | Display data bus |
| disp_wr_n_o | output | 1 | Active-low write strobe |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Sticky completion flag |

## Verification
An accepted start shows on `busy_o` and `done_o` one clock later, and the bench samples at the next falling edge. Each byte goes on the bus one cycle before the strobe falls. The strobe then stays low for STROBE_CYC cycles, which the bench measures edge to edge at falling clock edges and does not predict by count. An end pulse takes effect three rising edges after it is raised (two synchroniser flops, then the edge detector feeding the state register). For that reason the bench does not check completion at a fixed cycle. It waits for `done_o` and then watches ten more cycles to confirm the strobe stays quiet. Stray end pulses are timed to land while the sequencer waits for a slow byte, and spurious valid strobes are placed before any request is outstanding.

// File: rtl/pdisp_pkg.sv
package pdisp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FIRST,
      ST_SETUP,
      ST_LOW,
      ST_ENDW,
      ST_NEXT
   } seq_state_e;

endpackage

// File: rtl/pdisp_pulse_sync.sv
module pdisp_pulse_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic pulse_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pdisp_pulse_sync: STAGES must be at least 2");
   end

   // stages 0..STAGES-1 synchronise, stage STAGES holds the previous value
   logic [STAGES:0] sh_q;

   for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[0] <= 1'b0;
            else        sh_q[0] <= async_i;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[i] <= 1'b0;
            else        sh_q[i] <= sh_q[i-1];
         end
      end
   end

   assign pulse_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/pdisp_ctr.sv
module pdisp_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);

   if (W < 1) begin : g_bad_w
      $error("pdisp_ctr: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_o <= '0;
      else if (clr_i) cnt_o <= '0;
      else if (inc_i) cnt_o <= cnt_o + 1'b1;
   end

endmodule

// File: rtl/pdisp_prefetch.sv
module pdisp_prefetch #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_i,
   input  logic          vld_i,
   input  logic [DW-1:0] data_i,
   input  logic          take_i,
   output logic          have_o,
   output logic [DW-1:0] data_o
);

   logic pend_q;
   logic capture;

   // only one request is ever outstanding, so capture and take never meet
   assign capture = vld_i && pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         have_o <= 1'b0;
         data_o <= '0;
      end else begin
         if (req_i)        pend_q <= 1'b1;
         else if (capture) pend_q <= 1'b0;

         if (capture) begin
            have_o <= 1'b1;
            data_o <= data_i;
         end else if (take_i) begin
            have_o <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pdisp_wr_seq.sv
module pdisp_wr_seq
   import pdisp_pkg::*;
#(
   parameter int DW          = 8,
   parameter int CNT_W       = 16,
   parameter int STROBE_CYC  = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] xfer_cnt_i,
   output logic             fetch_req_o,
   input  logic             fetch_vld_i,
   input  logic [DW-1:0]    fetch_data_i,
   input  logic             step_async_i,
   output logic [DW-1:0]    disp_data_o,
   output logic             disp_wr_n_o,
   output logic             busy_o,
   output logic             done_o
);

   localparam int LOW_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;

   if (DW < 1) begin : g_bad_dw
      $error("pdisp_wr_seq: DW must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("pdisp_wr_seq: CNT_W must be at least 1");
   end
   if (STROBE_CYC < 1) begin : g_bad_strobe
      $error("pdisp_wr_seq: STROBE_CYC must be at least 1");
   end

   seq_state_e       state_q;
   logic [CNT_W-1:0] total_q;
   logic [CNT_W-1:0] sent_cnt;
   logic [CNT_W-1:0] end_cnt;
   logic             cnt_en;
   logic             have_nxt;
   logic [DW-1:0]    nxt_data;
   logic             start_ok;
   logic             zero_cnt;
   logic             take;
   logic             more;
   logic             issue_req;
   logic             end_step;
   logic             last_end;
   logic             low_last;

   pdisp_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (step_async_i),
      .pulse_o (cnt_en)
   );

   pdisp_prefetch #(.DW(DW)) u_pref (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (issue_req),
      .vld_i  (fetch_vld_i),
      .data_i (fetch_data_i),
      .take_i (take),
      .have_o (have_nxt),
      .data_o (nxt_data)
   );

   pdisp_ctr #(.W(CNT_W)) u_sent (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (start_ok),
      .inc_i (take),
      .cnt_o (sent_cnt)
   );

   pdisp_ctr #(.W(CNT_W)) u_ended (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (start_ok),
      .inc_i (end_step),
      .cnt_o (end_cnt)
   );

   always_comb begin
      start_ok  = (state_q == ST_IDLE) && start_i;
      zero_cnt  = (xfer_cnt_i == '0);
      take      = ((state_q == ST_FIRST) || (state_q == ST_NEXT)) && have_nxt;
      more      = ({1'b0, sent_cnt} + (CNT_W+1)'(1)) < {1'b0, total_q};
      issue_req = (start_ok && !zero_cnt) || (take && more);
      end_step  = cnt_en && (state_q == ST_ENDW);
      last_end  = end_step && (({1'b0, end_cnt} + (CNT_W+1)'(1)) == {1'b0, total_q});
   end

   if (STROBE_CYC == 1) begin : g_low_one
      assign low_last = 1'b1;
   end else begin : g_low_cnt
      logic [LOW_W-1:0] low_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                low_q <= '0;
         else if (state_q != ST_LOW) low_q <= '0;
         else                       low_q <= low_q + 1'b1;
      end
      assign low_last = (low_q == LOW_W'(STROBE_CYC - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         total_q     <= '0;
         disp_data_o <= '0;
         disp_wr_n_o <= 1'b1;
         fetch_req_o <= 1'b0;
         done_o      <= 1'b0;
      end else begin
         fetch_req_o <= issue_req;
         case (state_q)
            ST_IDLE: begin
               if (start_ok) begin
                  total_q <= xfer_cnt_i;
                  if (zero_cnt) begin
                     done_o <= 1'b1;
                  end else begin
                     done_o  <= 1'b0;
                     state_q <= ST_FIRST;
                  end
               end
            end
            ST_FIRST, ST_NEXT: begin
               if (take) begin
                  disp_data_o <= nxt_data;
                  state_q     <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               disp_wr_n_o <= 1'b0;
               state_q     <= ST_LOW;
            end
            ST_LOW: begin
               if (low_last) begin
                  disp_wr_n_o <= 1'b1;
                  state_q     <= ST_ENDW;
               end
            end
            ST_ENDW: begin
               if (last_end) begin
                  done_o  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (end_step) begin
                  state_q <= ST_NEXT;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/pdisp_wr_seq_chk.sv
module pdisp_wr_seq_chk #(
   parameter int DW    = 8,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [CNT_W-1:0] xfer_cnt_i,
   input logic             fetch_req_o,
   input logic [DW-1:0]    disp_data_o,
   input logic             disp_wr_n_o,
   input logic             busy_o,
   input logic             done_o
);

   AST_IDLE_WR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> disp_wr_n_o);                                        // R4

   AST_LOW_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!disp_wr_n_o && $past(!disp_wr_n_o)) |-> $stable(disp_data_o)); // R2

   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req_o |=> !fetch_req_o);                                   // R6

   AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && xfer_cnt_i == '0) |=> (done_o && !busy_o)); // R8

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && xfer_cnt_i != '0) |=> (busy_o && !done_o)); // R9

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);                                             // R9

   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> (!done_o || !busy_o));                   // R9

endmodule

bind pdisp_wr_seq pdisp_wr_seq_chk #(.DW(DW), .CNT_W(CNT_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .xfer_cnt_i  (xfer_cnt_i),
   .fetch_req_o (fetch_req_o),
   .disp_data_o (disp_data_o),
   .disp_wr_n_o (disp_wr_n_o),
   .busy_o      (busy_o),
   .done_o      (done_o)
);

// File: tb/pdisp_wr_seq_tb_top.sv
module pdisp_wr_seq_tb_top;

   localparam int DW         = 8;
   localparam int CNT_W      = 16;
   localparam int STROBE_CYC = 2;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             start_i;
   logic [CNT_W-1:0] xfer_cnt_i;
   logic             fetch_req_o;
   logic             fetch_vld_i = 1'b0;
   logic [DW-1:0]    fetch_data_i = '0;
   logic             step_async_i = 1'b0;
   logic [DW-1:0]    disp_data_o;
   logic             disp_wr_n_o;
   logic             busy_o;
   logic             done_o;

   always #10 clk = ~clk;

   pdisp_wr_seq #(.DW(DW), .CNT_W(CNT_W), .STROBE_CYC(STROBE_CYC)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .xfer_cnt_i   (xfer_cnt_i),
      .fetch_req_o  (fetch_req_o),
      .fetch_vld_i  (fetch_vld_i),
      .fetch_data_i (fetch_data_i),
      .step_async_i (step_async_i),
      .disp_data_o  (disp_data_o),
      .disp_wr_n_o  (disp_wr_n_o),
      .busy_o       (busy_o),
      .done_o       (done_o)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // environment state
   logic [DW-1:0] exp_b [0:63];
   logic [DW-1:0] cap_b [0:63];
   int  src_idx = 0, nfall = 0, nreq = 0, mon_err = 0;
   int  src_dly = 0, end_dly = 0, end_wid = 2;
   bit  stray_en = 0, junk = 0;
   bit  s_pend = 0;
   int  s_cd = 0, p_cd = 0, p_w = 0, st_cd = 0, st_w = 0, lowlen = 0;
   bit  p_arm = 0, st_arm = 0;
   logic          prev_wr = 1'b1;
   logic [DW-1:0] prev_data = '0;

   always @(negedge clk) begin
      // byte source
      fetch_vld_i = 1'b0;
      if (rst_n && fetch_req_o) begin
         nreq++;
         s_pend = 1;
         s_cd   = src_dly;
      end
      if (s_pend) begin
         if (s_cd == 0) begin
            fetch_vld_i  = 1'b1;
            fetch_data_i = DW'($urandom);
            if (src_idx < 64) exp_b[src_idx] = fetch_data_i;
            src_idx++;
            s_pend = 0;
         end else begin
            s_cd--;
         end
      end else if (junk) begin
         fetch_vld_i  = 1'b1;
         fetch_data_i = 8'hA5;
         junk = 0;
      end
      // strobe monitor
      if (prev_wr && !disp_wr_n_o) begin
         if (nfall < 64) cap_b[nfall] = disp_data_o;
         nfall++;
         lowlen = 1;
      end else if (!prev_wr && !disp_wr_n_o) begin
         lowlen++;
         if (disp_data_o != prev_data) mon_err++;
      end
      if (!prev_wr && disp_wr_n_o) begin
         if (lowlen != STROBE_CYC) mon_err++;
         p_arm = 1;
         p_cd  = end_dly;
         if (stray_en) begin
            st_arm = 1;
            st_cd  = 8;
         end
      end
      // end-of-cycle pulse generator
      if (p_w > 0) p_w--;
      if (p_arm) begin
         if (p_cd == 0) begin p_w = end_wid; p_arm = 0; end
         else p_cd--;
      end
      if (st_w > 0) st_w--;
      if (st_arm) begin
         if (st_cd == 0) begin st_w = 2; st_arm = 0; end
         else st_cd--;
      end
      step_async_i = (p_w > 0) || (st_w > 0);
      prev_wr   = disp_wr_n_o;
      prev_data = disp_data_o;
   end

   task automatic run(input int n, input bit dbl_start);
      int bad;
      src_idx = 0; nfall = 0; nreq = 0; mon_err = 0;
      @(negedge clk);
      start_i    = 1'b1;
      xfer_cnt_i = CNT_W'(n);
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1 && done_o == 1'b0, "R9 start clears done", int'(done_o), 0);
      if (dbl_start) begin
         repeat (6) @(negedge clk);
         start_i    = 1'b1;
         xfer_cnt_i = CNT_W'(n + 3);
         @(negedge clk);
         start_i = 1'b0;
      end
      for (int i = 0; i < 3000 && !done_o; i++) @(negedge clk);
      chk(done_o == 1'b1, "R4 done after last cycle", int'(done_o), 1);
      repeat (10) @(negedge clk);
      chk(nfall == n, "R3/R4 strobe count", nfall, n);
      bad = 0;
      for (int i = 0; i < n && i < 64; i++) if (cap_b[i] !== exp_b[i]) bad++;
      chk(bad == 0, "R3 byte order", bad, 0);
      chk(nreq == n, "R6 fetch requests", nreq, n);
      chk(mon_err == 0, "R2 strobe width/data stable", mon_err, 0);
      chk(busy_o == 1'b0 && done_o == 1'b1, "R9 done sticky", int'(done_o), 1);
      chk(disp_data_o == exp_b[n-1], "R11 bus holds last byte", int'(disp_data_o), int'(exp_b[n-1]));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; start_i = 1'b0; xfer_cnt_i = '0;
      repeat (3) @(negedge clk);
      chk(disp_wr_n_o == 1'b1, "R1 strobe idle high", int'(disp_wr_n_o), 1);
      chk(done_o == 1'b0 && busy_o == 1'b0, "R1 flags clear", int'(done_o), 0);
      chk(fetch_req_o == 1'b0 && disp_data_o == '0, "R1 request/bus clear", int'(disp_data_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R8: zero count completes at once
      nfall = 0; nreq = 0;
      start_i = 1'b1; xfer_cnt_i = '0;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b1 && busy_o == 1'b0, "R8 zero count done", int'(done_o), 1);
      repeat (5) @(negedge clk);
      chk(nfall == 0 && nreq == 0, "R8 no strobe or fetch", nfall + nreq, 0);

      // basic run
      src_dly = 0; end_dly = 0; end_wid = 2;
      run(3, 0);

      // R7: slow source, strobe waits
      src_dly = 7;
      run(3, 0);

      // R5: stray pulse while waiting for data
      src_dly = 20; stray_en = 1;
      run(3, 0);
      stray_en = 0;

      // R5: wide pulse counts once
      src_dly = 1; end_wid = 6;
      run(2, 0);

      // R9: start while busy ignored
      end_wid = 2; src_dly = 2;
      run(4, 1);

      // R10: valid without a request ignored
      junk = 1;
      repeat (3) @(negedge clk);
      src_dly = 0;
      run(2, 0);

      // random runs
      for (int k = 0; k < 8; k++) begin
         src_dly = $urandom_range(0, 6);
         end_dly = $urandom_range(0, 4);
         end_wid = $urandom_range(2, 5);
         run($urandom_range(1, 6), 0);
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule